// File: doc/BRIEF.md
# Super-Pixel Hit Capture Buffer

This block serves a 4x4 group of sixteen pixels. Each pixel drives an asynchronous discriminator line into it. Every line is brought into the 40 MHz bunch-crossing clock domain, and the block watches it for rising and falling transitions. When one or more pixels rise in the same clock cycle, the block opens a cluster. The cluster holds the value of the shared 12-bit bunch-crossing counter for that cycle, a 16-bit map of the pixels that rose, and a 4-bit time-over-threshold count for each pixel. Each count runs until that pixel's line falls.

Two register banks are used in ping-pong fashion, so two clusters can be measured or held at the same time. A cluster is offered to the readout side only when every pixel in it has fallen. It is then held on the outputs with a request flag until the reader acknowledges it with a one-cycle done pulse. Clusters are offered in the order in which they were opened. If a pixel rises while both banks are taken, that hit is discarded and a saturating counter of lost hits goes up by one.

Top module: `spixHitBuffer`

## Requirements
- R1: After reset, `reqValid` is 0, `lostHits` is 0 and `hdrHitMap` is 0.
- R2: The pixels whose synchronised inputs rise in the same clock cycle form one cluster. Its `hdrHitMap` has bit p set for pixel p, and its `hdrTime` equals the `bxCount` value sampled in that cycle.
- R3: A member pixel's ToT, at bits [4p+3:4p] of `totData`, equals the number of clock cycles its input stayed high. The value saturates at 15 and does not wrap.
- R4: `reqValid` stays 0 for a cluster while any of its member pixels is still high.
- R5: While `reqValid` is 1 and `readDone` is 0, `hdrTime`, `hdrHitMap` and `totData` do not change.
- R6: Two clusters can be held at once, and they are offered in the order they were opened, whichever one finished first.
- R7: A rise that arrives while both banks are occupied changes no stored cluster. `lostHits` then grows by the number of pixels that rose in that cycle, saturating at its maximum value.
- R8: `readDone` while `reqValid` is 0 has no effect on the next cluster that is offered.
- R9: Pixels that are not in a cluster's hit map report a ToT of 0.
- R10: A pixel that rises while an earlier cluster is still being measured opens a separate cluster with its own timestamp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz bunch-crossing clock |
| rstN | input | 1 | Active-low asynchronous reset |
| discIn | input | 16 | Asynchronous discriminator outputs, one per pixel |
| bxCount | input | 12 | Shared bunch-crossing counter |
| readDone | input | 1 | One-cycle acknowledge of the offered cluster |
| reqValid | output | 1 | A completed cluster is offered |
| hdrTime | output | 12 | Timestamp of the offered cluster |
| hdrHitMap | output | 16 | Hit map of the offered cluster |
| totData | output | 64 | Sixteen 4-bit ToT values, pixel p at bits [4p+3:4p] |
| lostHits | output | 8 | Saturating count of discarded pixel hits |

## Verification
The bench builds the block with its default parameters: sixteen pixels, a 12-bit timestamp, a 4-bit ToT and an 8-bit lost-hit counter. With a 4-bit ToT, a sweep of pulse widths from 1 to 20 cycles on every pixel position covers both the exact counts and the saturated ones. With an 8-bit lost counter, a few hundred dropped hits carry it into saturation. Mixed-width multi-pixel patterns, overlapping clusters and stray acknowledges cover the ordering, the hold behaviour and the overflow paths.

// File: rtl/spixPkg.sv
package spixPkg;
  typedef enum logic [1:0] {BANK_FREE, BANK_BUILD, BANK_FULL} bankStateT;

  typedef struct packed {
    logic open;
    logic bank;
  } ctrlStrobeT;
endpackage

// File: rtl/spixEdgeSync.sv
module spixEdgeSync #(
  parameter int NUM_PIX     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_PIX-1:0] discIn,
  output logic [NUM_PIX-1:0] level,
  output logic [NUM_PIX-1:0] rise,
  output logic [NUM_PIX-1:0] fall
);
  logic [NUM_PIX-1:0] prevQ;

  for (genvar i = 0; i < NUM_PIX; i++) begin : syncG
    logic [SYNC_STAGES-1:0] chainQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chainQ <= '0;
      else       chainQ <= {chainQ[SYNC_STAGES-2:0], discIn[i]};
    end
    assign level[i] = chainQ[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= '0;
    else       prevQ <= level;
  end

  assign rise = level & ~prevQ;
  assign fall = ~level & prevQ;
endmodule

// File: rtl/spixDatapath.sv
module spixDatapath
  import spixPkg::*;
#(
  parameter int NUM_PIX = 16,
  parameter int TS_W    = 12,
  parameter int TOT_W   = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrobeT               strobe,
  input  logic [NUM_PIX-1:0]       rise,
  input  logic [NUM_PIX-1:0]       fall,
  input  logic [NUM_PIX-1:0]       level,
  input  logic [TS_W-1:0]          bxCount,
  input  logic                     rdBank,
  output logic [1:0]               drained,
  output logic [TS_W-1:0]          hdrTime,
  output logic [NUM_PIX-1:0]       hdrHitMap,
  output logic [NUM_PIX*TOT_W-1:0] totFlat
);
  localparam logic [TOT_W-1:0] TOT_MAX = '1;

  for (genvar b = 0; b < 2; b++) begin : bankG
    logic [TS_W-1:0]    tsQ;
    logic [NUM_PIX-1:0] mapQ;
    logic [NUM_PIX-1:0] actQ;
    logic               openHere;

    assign openHere = strobe.open && (strobe.bank == 1'(b));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        tsQ  <= '0;
        mapQ <= '0;
        actQ <= '0;
      end else if (openHere) begin
        tsQ  <= bxCount;
        mapQ <= rise;
        actQ <= rise;
      end else begin
        actQ <= actQ & ~fall;
      end
    end

    assign drained[b] = ((actQ & ~fall) == '0);

    for (genvar p = 0; p < NUM_PIX; p++) begin : pixG
      logic [TOT_W-1:0] totQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                                   totQ <= '0;
        else if (openHere)                           totQ <= rise[p] ? TOT_W'(1) : '0;
        else if (actQ[p] && level[p] && totQ != TOT_MAX) totQ <= totQ + 1'b1;
      end

      // R9
      unmapped_tot_chk: assert property (@(posedge clk) disable iff (!rstN)
        !mapQ[p] |-> totQ == '0);
    end
  end

  assign hdrTime   = rdBank ? bankG[1].tsQ  : bankG[0].tsQ;
  assign hdrHitMap = rdBank ? bankG[1].mapQ : bankG[0].mapQ;

  for (genvar p = 0; p < NUM_PIX; p++) begin : outG
    assign totFlat[p*TOT_W +: TOT_W] = rdBank ? bankG[1].pixG[p].totQ : bankG[0].pixG[p].totQ;
  end
endmodule

// File: rtl/spixControl.sv
module spixControl
  import spixPkg::*;
#(
  parameter int NUM_PIX = 16,
  parameter int LOST_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_PIX-1:0] rise,
  input  logic [1:0]         drained,
  input  logic               readDone,
  output ctrlStrobeT         strobe,
  output logic               rdBank,
  output logic               reqValid,
  output logic [LOST_W-1:0]  lostHits
);
  localparam int CNT_W = $clog2(NUM_PIX + 1);
  localparam int SUM_W = ((LOST_W > CNT_W) ? LOST_W : CNT_W) + 1;
  localparam logic [SUM_W-1:0] LOST_MAX = SUM_W'({LOST_W{1'b1}});

  bankStateT        bankState [2];
  logic             wrPtr;
  logic             rdPtr;
  logic             anyRise;
  logic             canAlloc;
  logic             accept;
  logic [CNT_W-1:0] dropCnt;
  logic [SUM_W-1:0] lostSum;

  assign anyRise  = |rise;
  assign canAlloc = (bankState[wrPtr] == BANK_FREE);
  assign strobe.open = anyRise && canAlloc;
  assign strobe.bank = wrPtr;
  assign reqValid = (bankState[rdPtr] == BANK_FULL);
  assign accept   = reqValid && readDone;
  assign rdBank   = rdPtr;

  assign dropCnt = (anyRise && !canAlloc) ? CNT_W'($countones(rise)) : '0;
  assign lostSum = SUM_W'(lostHits) + SUM_W'(dropCnt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr    <= 1'b0;
      rdPtr    <= 1'b0;
      lostHits <= '0;
      for (int b = 0; b < 2; b++) bankState[b] <= BANK_FREE;
    end else begin
      if (strobe.open) wrPtr <= ~wrPtr;
      if (accept)      rdPtr <= ~rdPtr;
      lostHits <= (lostSum > LOST_MAX) ? LOST_W'(LOST_MAX) : LOST_W'(lostSum);
      for (int b = 0; b < 2; b++) begin
        if (strobe.open && wrPtr == 1'(b))                  bankState[b] <= BANK_BUILD;
        else if (bankState[b] == BANK_BUILD && drained[b])  bankState[b] <= BANK_FULL;
        else if (accept && rdPtr == 1'(b))                  bankState[b] <= BANK_FREE;
      end
    end
  end

  // R7
  lost_monotonic_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> lostHits >= $past(lostHits));

  // R8
  stray_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!reqValid && readDone) |=> rdPtr == $past(rdPtr));

  // R6
  order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bankState[rdPtr] == BANK_FREE) |-> (bankState[~rdPtr] == BANK_FREE));
endmodule

// File: rtl/spixHitBuffer.sv
module spixHitBuffer
  import spixPkg::*;
#(
  parameter int NUM_PIX     = 16,
  parameter int TS_W        = 12,
  parameter int TOT_W       = 4,
  parameter int LOST_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_PIX-1:0]       discIn,
  input  logic [TS_W-1:0]          bxCount,
  input  logic                     readDone,
  output logic                     reqValid,
  output logic [TS_W-1:0]          hdrTime,
  output logic [NUM_PIX-1:0]       hdrHitMap,
  output logic [NUM_PIX*TOT_W-1:0] totData,
  output logic [LOST_W-1:0]        lostHits
);
  logic [NUM_PIX-1:0] level;
  logic [NUM_PIX-1:0] rise;
  logic [NUM_PIX-1:0] fall;
  logic [1:0]         drained;
  logic               rdBank;
  ctrlStrobeT         strobe;

  spixEdgeSync #(.NUM_PIX(NUM_PIX), .SYNC_STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rstN(rstN), .discIn(discIn),
    .level(level), .rise(rise), .fall(fall));

  spixControl #(.NUM_PIX(NUM_PIX), .LOST_W(LOST_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .rise(rise), .drained(drained), .readDone(readDone),
    .strobe(strobe), .rdBank(rdBank), .reqValid(reqValid), .lostHits(lostHits));

  spixDatapath #(.NUM_PIX(NUM_PIX), .TS_W(TS_W), .TOT_W(TOT_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rise(rise), .fall(fall),
    .level(level), .bxCount(bxCount), .rdBank(rdBank), .drained(drained),
    .hdrTime(hdrTime), .hdrHitMap(hdrHitMap), .totFlat(totData));

  // R5
  hold_offer_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !readDone) |=> reqValid && $stable(hdrTime) && $stable(hdrHitMap) && $stable(totData));

  // R2
  nonempty_map_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> hdrHitMap != '0);
endmodule

// File: tb/test_spixHitBuffer.sv
module test_spixHitBuffer;
  localparam int CLK_PERIOD = 25;

  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] discIn;
  logic [11:0] bxCount;
  logic        readDone;
  logic        reqValid;
  logic [11:0] hdrTime;
  logic [15:0] hdrHitMap;
  logic [63:0] totData;
  logic [7:0]  lostHits;

  int errors = 0;
  int checks = 0;
  int pw [16];

  spixHitBuffer i_spixHitBuffer (
    .clk(clk), .rstN(rstN), .discIn(discIn), .bxCount(bxCount), .readDone(readDone),
    .reqValid(reqValid), .hdrTime(hdrTime), .hdrHitMap(hdrHitMap),
    .totData(totData), .lostHits(lostHits));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitValid();
    for (int i = 0; i < 60; i++) begin
      if (reqValid) break;
      tick(1);
    end
  endtask

  task automatic pop();
    readDone = 1'b1;
    tick(1);
    readDone = 1'b0;
  endtask

  function automatic logic [63:0] expTot();
    logic [63:0] v = '0;
    for (int p = 0; p < 16; p++) v[p*4 +: 4] = (pw[p] > 15) ? 4'd15 : 4'(pw[p]);
    return v;
  endfunction

  function automatic logic [15:0] expMap();
    logic [15:0] m = '0;
    for (int p = 0; p < 16; p++) m[p] = (pw[p] != 0);
    return m;
  endfunction

  // Drives pw[] as simultaneous pulses; returns 1 if reqValid rose while any pulse was high (R4)
  task automatic runCluster(logic [11:0] bx, output bit early);
    int maxW = 0;
    early = 0;
    for (int p = 0; p < 16; p++) if (pw[p] > maxW) maxW = pw[p];
    bxCount = bx;
    for (int c = 0; c < maxW; c++) begin
      for (int p = 0; p < 16; p++) discIn[p] = (c < pw[p]);
      tick(1);
      if (reqValid) early = 1;
    end
    discIn = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit early;
    logic [11:0] tHold;
    logic [15:0] mHold;
    logic [63:0] vHold;
    rstN = 1'b0; discIn = '0; bxCount = '0; readDone = 1'b0;
    tick(3);
    // R1: reset state
    check("R1 reqValid", reqValid, 0);
    check("R1 lostHits", lostHits, 0);
    check("R1 hdrHitMap", hdrHitMap, 0);
    rstN = 1'b1;
    tick(2);

    // R3 R9 R2: single-pixel width sweep, saturation beyond 15
    for (int w = 1; w <= 20; w++) begin
      foreach (pw[p]) pw[p] = 0;
      pw[w % 16] = w;
      runCluster(12'((w * 211) % 4096), early);
      waitValid();
      check("R2 single time", hdrTime, (w * 211) % 4096);
      check("R2 single map", hdrHitMap, expMap());
      check("R3 R9 single tot", totData, expTot());
      pop();
      tick(1);
    end

    // R2 R3 R4: multi-pixel patterns with mixed widths
    for (int pat = 0; pat < 8; pat++) begin
      foreach (pw[p]) pw[p] = (((p + pat) % 3) != 0) ? ((p * 5 + pat * 3) % 18) + 1 : 0;
      runCluster(12'(4095 - pat * 37), early);
      check("R4 no early offer", early, 0);
      waitValid();
      check("R2 multi time", hdrTime, 4095 - pat * 37);
      check("R2 multi map", hdrHitMap, expMap());
      check("R3 multi tot", totData, expTot());
      pop();
      tick(1);
    end

    // R6 R10: long cluster opened first, short one finishes first
    bxCount = 12'd100;
    discIn = 16'h0001;
    tick(4);
    bxCount = 12'd200;
    discIn = 16'h0021;
    tick(2);
    discIn = 16'h0001;
    tick(14);
    discIn = '0;
    tick(8);
    check("R6 first offered time", hdrTime, 100);
    check("R10 first map", hdrHitMap, 16'h0001);
    check("R3 first tot sat", totData, 64'hF);
    // R5: hold while not acknowledged
    tHold = hdrTime; mHold = hdrHitMap; vHold = totData;
    for (int i = 0; i < 5; i++) begin bxCount = 12'(i * 999); tick(1); end
    check("R5 hold time", hdrTime, tHold);
    check("R5 hold map", hdrHitMap, mHold);
    check("R5 hold tot", totData, vHold);
    check("R5 hold valid", reqValid, 1);
    pop();
    check("R6 second time", hdrTime, 200);
    check("R10 second map", hdrHitMap, 16'h0020);
    check("R3 second tot", totData, 64'h2 << 20);

    // R7: fill the freed bank, then rise while both occupied
    foreach (pw[p]) pw[p] = 0;
    pw[9] = 3;
    runCluster(12'd300, early);
    tick(6);
    discIn = 16'h000E;
    tick(2);
    discIn = '0;
    tick(6);
    check("R7 lost count", lostHits, 3);
    check("R7 offered unchanged", hdrTime, 200);
    pop();
    check("R7 third time", hdrTime, 300);
    check("R7 dropped not merged", hdrHitMap, 16'h0200);
    check("R7 third tot", totData, 64'h3 << 36);
    pop();
    tick(2);
    check("R6 buffers empty", reqValid, 0);

    // R8: stray acknowledge, then a fresh cluster must still be offered
    pop();
    tick(2);
    check("R8 still idle", reqValid, 0);
    foreach (pw[p]) pw[p] = 0;
    pw[4] = 5;
    runCluster(12'd400, early);
    waitValid();
    check("R8 offered after stray", reqValid, 1);
    check("R8 time", hdrTime, 400);
    check("R8 tot", totData, 64'h5 << 16);
    pop();
    tick(2);

    // R7: saturation of the lost counter
    bxCount = 12'd500;
    discIn = 16'h0001; tick(2); discIn = '0; tick(3);
    discIn = 16'h0002; tick(2); discIn = '0; tick(6);
    for (int i = 0; i < 90; i++) begin
      discIn = 16'h0E00; tick(1);
      discIn = '0; tick(2);
    end
    tick(4);
    check("R7 lost saturated", lostHits, 255);
    check("R7 first kept", hdrHitMap, 16'h0001);
    pop();
    check("R7 second kept", hdrHitMap, 16'h0002);
    pop();
    tick(2);
    check("R7 drained", reqValid, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule